// File: doc/BRIEF.md
# USB Root Hub Port Status and Control Register

This block holds one 32-bit status and control word for each downstream port of a full-speed USB host root hub. Host software reaches it over a simple register bus: a read code selects which port's word appears on the read data, and a write strobe with a write code delivers a command word to one port. The lower half of each word reports the live state of the port: connected, enabled, suspended, overcurrent, in reset, powered and low-speed. The upper half holds sticky change flags. Hardware events set these flags. Software clears them by writing ones.

The block takes connect, overcurrent and low-speed indications from each port, a 1 kHz tick, and a flag from the host transfer engine that is high while a bus transaction is running. It drives reset, enable, suspend and power to each port. It times the port reset pulse by counting ticks. When the pulse ends it enables the port and raises a completion flag.

A write that would change port state while a transaction is running is held in a one-entry buffer per port. It takes effect on the first cycle with no transaction. A later held write replaces an earlier one. Flag-clearing writes are never held. The write strobe has no ready signal: every write is accepted in the cycle it is presented, so the bus never sees back-pressure.

Top module: `usbp_status_top`

## Requirements
- R1: Port i (0-based) is read at code 0x15+i and written at code 0x95+i. Any other read code returns 0, and a write at any other code, including a read code, changes nothing.
- R2: Bits 31:21, 15:10 and 7:5 of every word read 0, and the values written to them have no effect.
- R3: After reset every bit of every word is 0, and all port outputs are 0.
- R4: The flags are set by hardware events: connect change (bit 16), enable cleared by hardware (bit 17), suspend left by resume (bit 18), overcurrent indicator changed (bit 19) and reset complete (bit 20). When a set and a clear hit the same flag in the same cycle, the set wins.
- R5: Writing 1 to any of bits 20:16 clears that flag. Writing 0 leaves it unchanged.
- R6: A write with bit 8 set turns power on, and one with bit 9 set turns power off (this also clears enable and suspend). Bit 1 enables the port only when it is connected and powered, and bit 0 disables it. Bit 2 suspends the port only when it is enabled. Bit 3 resumes it. When a set and a clear command are in the same write, the clear wins.
- R7: Writing bit 4 on a connected, powered port starts a reset. Bit 4 and the reset output stay high until the RESET_TICKS-th tick after the start (10 by default). At that edge bit 4 clears, bit 1 sets and bit 20 sets.
- R8: While the transaction flag is high, a write carrying any of bits 0-4, 8 or 9 is held and changes nothing. It is applied on the first clock edge with the flag low. Flag clears in the same write apply at once.
- R9: A second held write replaces the first, so only the most recent one is applied.
- R10: Bit 3 follows the overcurrent input one cycle late. When overcurrent asserts, the port is disabled and bit 17 is set.
- R11: Bit 0 is the connect input gated by power, registered. Bit 9 is low-speed gated by the connection. A disconnect clears enable, suspend and reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1k_i | input | 1 | One-cycle pulse every millisecond |
| xact_busy_i | input | 1 | High while a bus transaction is in progress |
| wr_valid_i | input | 1 | Write strobe |
| wr_code_i | input | 8 | Write register code |
| wr_data_i | input | 32 | Write command word |
| rd_code_i | input | 8 | Read register code |
| rd_data_o | output | 32 | Selected port word (combinational) |
| connect_i | input | NUM_PORTS | Device present per port |
| overcur_i | input | NUM_PORTS | Overcurrent per port |
| lowspeed_i | input | NUM_PORTS | Low-speed device per port |
| port_reset_o | output | NUM_PORTS | Reset signalling request |
| port_enable_o | output | NUM_PORTS | Port enabled |
| port_suspend_o | output | NUM_PORTS | Port suspended |
| port_power_o | output | NUM_PORTS | Port power switch |

## Verification
The bench aims at three corner cases. The first is held writes: a design that applied a command during a transaction would enable the port too early. One that kept the first held command instead of the last would cut power when it should enable the port. The second is the reset pulse, which is checked one tick before its end and again at the end. An off-by-one counter would drop bit 4 early or late, or fail to set the enable and completion flags together. The third is write-one-to-clear with reserved and foreign-code writes: a design that cleared flags on zeros, let reserved bits through, or decoded a read code as a write would change words that must stay as they were.

// File: rtl/usbp_pkg.sv
package usbp_pkg;
  localparam int WORD_W   = 32;
  localparam int FLAG_W   = 5;
  localparam int FLAG_LSB = 16;

  // flag index inside the 5-bit change field
  localparam int F_CONN  = 0;
  localparam int F_EN    = 1;
  localparam int F_SUSP  = 2;
  localparam int F_OVC   = 3;
  localparam int F_RSTOK = 4;

  typedef struct packed {
    logic pwr_off;
    logic pwr_on;
    logic rst_go;
    logic resume;
    logic susp;
    logic en_set;
    logic en_clr;
  } ctl_t;

  function automatic ctl_t decode_ctl(input logic [WORD_W-1:0] d);
    ctl_t c;
    c.pwr_off = d[9];
    c.pwr_on  = d[8];
    c.rst_go  = d[4];
    c.resume  = d[3];
    c.susp    = d[2];
    c.en_set  = d[1];
    c.en_clr  = d[0];
    return c;
  endfunction
endpackage

// File: rtl/usbp_w1c_flags.sv
module usbp_w1c_flags #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  for (genvar k = 0; k < W; k++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)        q[k] <= 1'b0;
      else if (set_i[k]) q[k] <= 1'b1;
      else if (clr_i[k]) q[k] <= 1'b0;
    end
  end

  assign q_o = q;

  // R5: a clear without a matching set empties the flag
  p_w1c_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_i & ~set_i) != '0) |=> ((q & $past(clr_i & ~set_i)) == '0));

  // R4: an event always leaves its flag set
  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/usbp_reset_timer.sv
module usbp_reset_timer #(
  parameter int TICKS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic abort_i,
  input  logic tick_i,
  output logic active_o,
  output logic done_o
);
  localparam int CW = $clog2(TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic          active_q;
  logic [CW-1:0] cnt_q;

  assign done_o   = active_q && tick_i && !abort_i && (cnt_q == LAST);
  assign active_o = active_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (abort_i) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (active_q && tick_i) begin
      if (cnt_q == LAST) begin
        active_q <= 1'b0;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R7: completion ends the pulse
  p_done_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !active_o);

  // R7: the count never passes its limit
  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/usbp_port_core.sv
module usbp_port_core
  import usbp_pkg::*;
#(
  parameter int RESET_TICKS = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 connect_i,
  input  logic                 overcur_i,
  input  logic                 lowspeed_i,
  input  logic                 tick_i,
  input  logic                 busy_i,
  input  logic                 wr_hit_i,
  input  ctl_t                 wr_ctl_i,
  input  logic [FLAG_W-1:0]    wr_clr_i,
  output logic [WORD_W-1:0]    word_o,
  output logic                 reset_o,
  output logic                 enable_o,
  output logic                 suspend_o,
  output logic                 power_o
);
  logic pwr_q, en_q, sus_q, conn_q, oc_q, ls_q;
  logic pend_v, pend_vn;
  ctl_t pend_q, pend_n;
  logic apply_v;
  ctl_t act;
  logic ctl_any;
  logic conn_now, conn_fall, oc_rise, pwr_off_go, hw_kill;
  logic prs, rst_done, rst_start, rst_abort;
  logic [FLAG_W-1:0] flag_set, flags;

  assign ctl_any = wr_hit_i && (wr_ctl_i != '0);

  // hold-or-apply selection for status-changing writes
  always_comb begin
    apply_v = 1'b0;
    act     = '0;
    pend_n  = pend_q;
    pend_vn = pend_v;
    if (busy_i) begin
      if (ctl_any) begin
        pend_n  = wr_ctl_i;
        pend_vn = 1'b1;
      end
    end else if (pend_v) begin
      apply_v = 1'b1;
      act     = pend_q;
      pend_vn = ctl_any;
      if (ctl_any) pend_n = wr_ctl_i;
    end else if (ctl_any) begin
      apply_v = 1'b1;
      act     = wr_ctl_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_v <= 1'b0;
      pend_q <= '0;
    end else begin
      pend_v <= pend_vn;
      pend_q <= pend_n;
    end
  end

  assign conn_now   = connect_i && pwr_q;
  assign conn_fall  = conn_q && !conn_now;
  assign oc_rise    = overcur_i && !oc_q;
  assign pwr_off_go = apply_v && act.pwr_off;
  assign hw_kill    = !conn_now || pwr_off_go || oc_rise;

  assign rst_abort = !conn_now || pwr_off_go;
  assign rst_start = apply_v && act.rst_go && conn_q && pwr_q && !prs && !rst_abort;

  usbp_reset_timer #(.TICKS(RESET_TICKS)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (rst_start),
    .abort_i  (rst_abort),
    .tick_i   (tick_i),
    .active_o (prs),
    .done_o   (rst_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwr_q  <= 1'b0;
      en_q   <= 1'b0;
      sus_q  <= 1'b0;
      conn_q <= 1'b0;
      oc_q   <= 1'b0;
      ls_q   <= 1'b0;
    end else begin
      conn_q <= conn_now;
      oc_q   <= overcur_i;
      ls_q   <= lowspeed_i && conn_now;

      if (pwr_off_go)                  pwr_q <= 1'b0;
      else if (apply_v && act.pwr_on)  pwr_q <= 1'b1;

      if (hw_kill)                                  en_q <= 1'b0;
      else if (apply_v && act.en_clr)               en_q <= 1'b0;
      else if (rst_done)                            en_q <= 1'b1;
      else if (apply_v && act.en_set && conn_q)     en_q <= 1'b1;

      if (hw_kill)                                      sus_q <= 1'b0;
      else if (apply_v && (act.resume || act.en_clr))   sus_q <= 1'b0;
      else if (apply_v && act.susp && en_q)             sus_q <= 1'b1;
    end
  end

  always_comb begin
    flag_set          = '0;
    flag_set[F_CONN]  = conn_q != conn_now;
    flag_set[F_EN]    = en_q && hw_kill;
    flag_set[F_SUSP]  = apply_v && act.resume && sus_q && !hw_kill;
    flag_set[F_OVC]   = oc_q != overcur_i;
    flag_set[F_RSTOK] = rst_done;
  end

  usbp_w1c_flags #(.W(FLAG_W)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (flag_set),
    .clr_i (wr_hit_i ? wr_clr_i : '0),
    .q_o   (flags)
  );

  assign word_o = {11'b0, flags, 6'b0, ls_q, pwr_q, 3'b0, prs, oc_q, sus_q, en_q, conn_q};

  assign reset_o   = prs;
  assign enable_o  = en_q;
  assign suspend_o = sus_q;
  assign power_o   = pwr_q;

  // R6: an enabled port is always powered
  p_enable_needs_power_r6: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |-> pwr_q);

  // R8: a held write stays held while the bus is busy
  p_pend_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_v && busy_i) |=> pend_v);

  // R8: a held write drains on the first idle cycle
  p_pend_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_v && !busy_i && !ctl_any) |=> !pend_v);

  // R7: the reset pulse only ends on a tick or a disconnect
  p_prs_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (prs && !tick_i && conn_now && !pwr_off_go) |=> prs);

  // R10: an overcurrent edge raises its change flag
  p_ovc_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (overcur_i != oc_q) |=> flags[F_OVC]);

  // R11: a disconnect removes enable
  p_disc_disables_r11: assert property (@(posedge clk) disable iff (!rst_n)
    conn_fall |=> !en_q);
endmodule

// File: rtl/usbp_status_top.sv
module usbp_status_top
  import usbp_pkg::*;
#(
  parameter int         NUM_PORTS   = 2,
  parameter int         RESET_TICKS = 10,
  parameter logic [7:0] RD_BASE     = 8'h15,
  parameter logic [7:0] WR_BASE     = 8'h95
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_1k_i,
  input  logic                 xact_busy_i,
  input  logic                 wr_valid_i,
  input  logic [7:0]           wr_code_i,
  input  logic [31:0]          wr_data_i,
  input  logic [7:0]           rd_code_i,
  output logic [31:0]          rd_data_o,
  input  logic [NUM_PORTS-1:0] connect_i,
  input  logic [NUM_PORTS-1:0] overcur_i,
  input  logic [NUM_PORTS-1:0] lowspeed_i,
  output logic [NUM_PORTS-1:0] port_reset_o,
  output logic [NUM_PORTS-1:0] port_enable_o,
  output logic [NUM_PORTS-1:0] port_suspend_o,
  output logic [NUM_PORTS-1:0] port_power_o
);
  logic [WORD_W-1:0] words [NUM_PORTS];
  ctl_t              wr_ctl;
  logic [FLAG_W-1:0] wr_clr;
  logic              unused_bits;

  assign wr_ctl      = decode_ctl(wr_data_i);
  assign wr_clr      = wr_data_i[FLAG_LSB +: FLAG_W];
  assign unused_bits = ^{wr_data_i[31:21], wr_data_i[15:10], wr_data_i[7:5]};

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
    logic hit;
    assign hit = wr_valid_i && (wr_code_i == (WR_BASE + 8'(i)));

    usbp_port_core #(.RESET_TICKS(RESET_TICKS)) u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .connect_i  (connect_i[i]),
      .overcur_i  (overcur_i[i]),
      .lowspeed_i (lowspeed_i[i]),
      .tick_i     (tick_1k_i),
      .busy_i     (xact_busy_i),
      .wr_hit_i   (hit),
      .wr_ctl_i   (wr_ctl),
      .wr_clr_i   (wr_clr),
      .word_o     (words[i]),
      .reset_o    (port_reset_o[i]),
      .enable_o   (port_enable_o[i]),
      .suspend_o  (port_suspend_o[i]),
      .power_o    (port_power_o[i])
    );
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (rd_code_i == (RD_BASE + 8'(i))) rd_data_o = words[i];
    end
  end

  // R2: reserved upper bits never read as one
  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data_o[31:21] == '0);

  // R7: a port in reset is also powered
  p_reset_powered_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (port_reset_o & ~port_power_o) == '0);
endmodule

// File: tb/usbp_status_top_bench.sv
`timescale 1ns/1ps
module usbp_status_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        busy = 1'b0;
  logic        wr_valid = 1'b0;
  logic [7:0]  wr_code = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_code = '0;
  logic [31:0] rd_data;
  logic [1:0]  conn = '0, oc = '0, ls = '0;
  logic [1:0]  prst, pen, psus, ppwr;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  usbp_status_top u_usbp_status_top (
    .clk(clk), .rst_n(rst_n), .tick_1k_i(tick), .xact_busy_i(busy),
    .wr_valid_i(wr_valid), .wr_code_i(wr_code), .wr_data_i(wr_data),
    .rd_code_i(rd_code), .rd_data_o(rd_data),
    .connect_i(conn), .overcur_i(oc), .lowspeed_i(ls),
    .port_reset_o(prst), .port_enable_o(pen),
    .port_suspend_o(psus), .port_power_o(ppwr)
  );

  typedef struct packed {
    logic [1:0]  c, o, l;
    logic        wv;
    logic [7:0]  code;
    logic [31:0] data, e1, e2;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{2'b00,2'b00,2'b00,1'b0,8'h00,32'h0,       32'h00000,32'h000}, // idle
    '{2'b00,2'b00,2'b00,1'b1,8'h95,32'h100,     32'h00100,32'h000}, // R6 power on
    '{2'b01,2'b00,2'b00,1'b0,8'h00,32'h0,       32'h10101,32'h000}, // R11 R4 connect
    '{2'b01,2'b00,2'b01,1'b0,8'h00,32'h0,       32'h10301,32'h000}, // R11 low speed
    '{2'b01,2'b00,2'b01,1'b1,8'h95,32'h10000,   32'h00301,32'h000}, // R5 clear
    '{2'b01,2'b00,2'b01,1'b1,8'h95,32'h2,       32'h00303,32'h000}, // R6 enable
    '{2'b01,2'b00,2'b01,1'b1,8'h95,32'h4,       32'h00307,32'h000}, // R6 suspend
    '{2'b01,2'b00,2'b01,1'b1,8'h95,32'h8,       32'h40303,32'h000}, // R6 R4 resume
    '{2'b01,2'b00,2'b01,1'b1,8'h95,32'h40000,   32'h00303,32'h000}, // R5
    '{2'b01,2'b01,2'b01,1'b0,8'h00,32'h0,       32'hA0309,32'h000}, // R10 oc rise
    '{2'b01,2'b00,2'b01,1'b0,8'h00,32'h0,       32'hA0301,32'h000}, // R10 oc fall
    '{2'b01,2'b00,2'b01,1'b1,8'h95,32'hFFE80000,32'h20301,32'h000}, // R2 R5
    '{2'b01,2'b00,2'b01,1'b1,8'h96,32'h100,     32'h20301,32'h100}, // R1 port 2
    '{2'b01,2'b00,2'b01,1'b1,8'h15,32'h20000,   32'h20301,32'h100}, // R1 read code
    '{2'b01,2'b00,2'b01,1'b1,8'h95,32'h20000,   32'h00301,32'h100}, // R5
    '{2'b01,2'b00,2'b01,1'b1,8'h95,32'h200,     32'h00201,32'h100}, // R6 power off
    '{2'b01,2'b00,2'b01,1'b0,8'h00,32'h0,       32'h10000,32'h100}  // R11 disconnect
  };

  task automatic cyc();
    @(posedge clk);
    #1;
    wr_valid = 1'b0;
    tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] code, input logic [31:0] data);
    wr_valid = 1'b1;
    wr_code = code;
    wr_data = data;
    cyc();
  endtask

  task automatic chk_word(input logic [7:0] code, input logic [31:0] exp, input string req);
    rd_code = code;
    #0.4;
    checks++;
    if (rd_data !== exp) begin
      errors++;
      $display("FAIL %s code %h: actual %h expected %h", req, code, rd_data, exp);
    end
  endtask

  task automatic chk_bit(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R3 reset state
    chk_word(8'h15, 32'h0, "R3");
    chk_word(8'h16, 32'h0, "R3");
    chk_bit(|{prst, pen, psus, ppwr}, 1'b0, "R3 outputs");
    chk_word(8'h17, 32'h0, "R1 unmapped");

    for (int v = 0; v < NV; v++) begin
      conn = VECS[v].c;
      oc = VECS[v].o;
      ls = VECS[v].l;
      if (VECS[v].wv) wr(VECS[v].code, VECS[v].data);
      else cyc();
      chk_word(8'h15, VECS[v].e1, "R1-table port1");
      chk_word(8'h16, VECS[v].e2, "R1-table port2");
    end

    // fresh start for held-write tests
    rst_n = 1'b0;
    conn = '0; oc = '0; ls = '0;
    cyc();
    rst_n = 1'b1;
    wr(8'h95, 32'h100);
    conn = 2'b01;
    cyc();
    chk_word(8'h15, 32'h10101, "R11 reconnect");

    busy = 1'b1;
    wr(8'h95, 32'h10000);
    chk_word(8'h15, 32'h00101, "R8 flag clear immediate");
    wr(8'h95, 32'h200);
    chk_word(8'h15, 32'h00101, "R8 power off held");
    wr(8'h95, 32'h2);
    chk_word(8'h15, 32'h00101, "R8 enable held");
    busy = 1'b0;
    cyc();
    chk_word(8'h15, 32'h00103, "R9 latest applied");
    chk_bit(pen[0], 1'b1, "R9 enable out");
    cyc();
    chk_word(8'h15, 32'h00103, "R9 earlier discarded");
    chk_bit(ppwr[0], 1'b1, "R9 power kept");

    // reset pulse timing
    wr(8'h95, 32'h10);
    chk_word(8'h15, 32'h00113, "R7 reset started");
    chk_bit(prst[0], 1'b1, "R7 reset out");
    for (int t = 0; t < 9; t++) begin
      tick = 1'b1;
      cyc();
      cyc();
    end
    chk_word(8'h15, 32'h00113, "R7 before last tick");
    tick = 1'b1;
    cyc();
    chk_word(8'h15, 32'h100103, "R7 reset done");
    chk_bit(prst[0], 1'b0, "R7 reset out low");
    wr(8'h95, 32'h0);
    chk_word(8'h15, 32'h100103, "R5 zero write keeps flags");

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule